// File: doc/BRIEF.md
# Block-Protected Memory Write Gate

This block sits in front of a 512-byte, byte-addressed storage array and decides, one request at a time, whether a write may reach it. A 2-bit protection code selects how much of the array is locked. The locked region always grows downward from the highest address. A write that falls inside the locked region is dropped silently, and the array keeps its old contents. The block then raises a one-cycle reject pulse and a one-cycle pulse that tells the configuration sequencer to clear its register-write-enable latch. Writes outside the region go into the array and raise a one-cycle accept pulse.

Reads are never gated. They return the stored byte one cycle after the request. The array is a synchronous RAM held inside the block. The protection code is sampled on the same clock edge as each request, so a change to the code applies only to the requests that follow it.

Top module: `wpg_gate`

## Requirements
- R1: While reset is held and in the first cycle after it, wr_accept, wr_reject, rwel_clear and rd_valid are all low.
- R2: With prot_code 00, every write (req_valid=1, req_write=1) is stored, and wr_accept is high for exactly the one cycle after the request.
- R3: With prot_code 01, writes to 180h–1FFh are rejected and writes to 000h–17Fh are accepted.
- R4: With prot_code 10, writes to 100h–1FFh are rejected and writes to 000h–0FFh are accepted.
- R5: With prot_code 11, writes to every address 000h–1FFh are rejected.
- R6: A rejected write leaves the addressed byte unchanged, as a later read shows.
- R7: A rejected write raises rwel_clear together with wr_reject for exactly the one cycle after the request. Accepted writes and reads never raise rwel_clear.
- R8: wr_accept and wr_reject are never high together. Neither one is raised in the cycle after a read or an idle cycle.
- R9: A read (req_valid=1, req_write=0) raises rd_valid in the following cycle with rd_data equal to the stored byte, whatever prot_code holds.
- R10: prot_code is sampled on the edge that takes each request. Changing it between two back-to-back requests changes the outcome of the second request only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 9 | Byte address |
| req_wdata | input | 8 | Write data |
| prot_code | input | 2 | Protection code: 00 none, 01 upper quarter, 10 upper half, 11 whole array |
| rd_data | output | 8 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read data valid pulse |
| wr_accept | output | 1 | Write stored pulse |
| wr_reject | output | 1 | Write dropped pulse |
| rwel_clear | output | 1 | Clear request for the register-write-enable latch |

## Verification
The bench builds the block with its default parameters: a 9-bit address, an 8-bit data path, and the latch-clear output enabled. Because the address is only 9 bits wide, the bench can fill the whole array in a few hundred cycles. It can then check each protection boundary at 0FFh/100h and 17Fh/180h against a reference copy of every byte. With the latch-clear option enabled, each rejected write must also show up on rwel_clear, which ties R7 to the same boundary cases.

// File: rtl/wpg_pkg.sv
package wpg_pkg;

   typedef enum logic [1:0] {
      PROT_NONE = 2'b00,
      PROT_QTR  = 2'b01,
      PROT_HALF = 2'b10,
      PROT_ALL  = 2'b11
   } prot_e;

endpackage

// File: rtl/wpg_region_decode.sv
module wpg_region_decode
   import wpg_pkg::*;
(
   input  logic [1:0] code,
   input  logic [1:0] addr_hi,
   output logic       locked
);

   always_comb begin
      unique case (prot_e'(code))
         PROT_NONE: locked = 1'b0;
         PROT_QTR:  locked = (addr_hi == 2'b11);
         PROT_HALF: locked = addr_hi[1];
         default:   locked = 1'b1;
      endcase
   end

endmodule

// File: rtl/wpg_ram.sv
module wpg_ram #(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              re,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) begin
         store[addr] <= wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (re) begin
         rdata <= store[addr];
      end
   end

endmodule

// File: rtl/wpg_gate.sv
module wpg_gate #(
   parameter int ADDR_W          = 9,
   parameter int DATA_W          = 8,
   parameter bit CLEAR_ON_REJECT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        prot_code,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_valid,
   output logic              wr_accept,
   output logic              wr_reject,
   output logic              rwel_clear
);

   localparam int HI_LSB = ADDR_W - 2;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("wpg_gate: ADDR_W must be at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("wpg_gate: DATA_W must be at least 1");
   end

   logic locked;
   logic wr_req;
   logic rd_req;
   logic wr_go;
   logic wr_blk;

   wpg_region_decode u_dec (
      .code    (prot_code),
      .addr_hi (req_addr[ADDR_W-1:HI_LSB]),
      .locked  (locked)
   );

   assign wr_req = req_valid & req_write;
   assign rd_req = req_valid & ~req_write;
   assign wr_go  = wr_req & ~locked;
   assign wr_blk = wr_req & locked;

   wpg_ram #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_ram (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_go),
      .re    (rd_req),
      .addr  (req_addr),
      .wdata (req_wdata),
      .rdata (rd_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid  <= 1'b0;
         wr_accept <= 1'b0;
         wr_reject <= 1'b0;
      end else begin
         rd_valid  <= rd_req;
         wr_accept <= wr_go;
         wr_reject <= wr_blk;
      end
   end

   if (CLEAR_ON_REJECT) begin : g_clr
      assign rwel_clear = wr_reject;
   end else begin : g_noclr
      assign rwel_clear = 1'b0;
   end

   // R8
   accept_reject_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_accept && wr_reject));

   // R8
   no_wr_pulse_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_valid && req_write) |=> !wr_accept && !wr_reject);

   // R2
   open_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && prot_code == 2'b00) |=> wr_accept);

   // R5
   full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && prot_code == 2'b11) |=> wr_reject && !wr_accept);

   // R9
   read_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rd_valid);

   // R7
   clear_only_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rwel_clear |-> wr_reject);

endmodule

// File: tb/wpg_gate_tb_top.sv
module wpg_gate_tb_top;

   localparam int AW = 9;
   localparam int DW = 8;
   localparam int DEPTH = 512;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic [1:0]    prot_code = 2'b00;
   logic [DW-1:0] rd_data;
   logic          rd_valid;
   logic          wr_accept;
   logic          wr_reject;
   logic          rwel_clear;

   int tests = 0;
   int fails = 0;
   int cycles = 0;
   int model [DEPTH];

   always #4 clk = ~clk;

   wpg_gate dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .prot_code  (prot_code),
      .rd_data    (rd_data),
      .rd_valid   (rd_valid),
      .wr_accept  (wr_accept),
      .wr_reject  (wr_reject),
      .rwel_clear (rwel_clear)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         fails = fails + 1;
         $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   function automatic bit is_locked(input int code, input int addr);
      int first;
      case (code)
         0: first = DEPTH;
         1: first = 384;
         2: first = 256;
         default: first = 0;
      endcase
      return addr >= first;
   endfunction

   task automatic step(input string tag, input bit v, input bit w,
                       input int addr, input int data, input int code);
      bit e_acc, e_rej, e_rdv;
      int e_rd;
      req_valid = v;
      req_write = w;
      req_addr  = AW'(addr);
      req_wdata = DW'(data);
      prot_code = 2'(code);
      e_acc = v && w && !is_locked(code, addr);
      e_rej = v && w && is_locked(code, addr);
      e_rdv = v && !w;
      e_rd  = model[addr];
      if (e_acc) model[addr] = data & 8'hFF;
      @(negedge clk);
      tests = tests + 1;
      if (wr_accept !== e_acc || wr_reject !== e_rej || rwel_clear !== e_rej ||
          rd_valid !== e_rdv || (e_rdv && rd_data !== DW'(e_rd))) begin
         fails = fails + 1;
         $display("FAIL %s addr=%h code=%0d: actual acc=%b rej=%b clr=%b rdv=%b rd=%h expected acc=%b rej=%b clr=%b rdv=%b rd=%h",
                  tag, addr, code, wr_accept, wr_reject, rwel_clear, rd_valid, rd_data,
                  e_acc, e_rej, e_rej, e_rdv, e_rd[7:0]);
      end
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model[i] = 0;
      @(negedge clk);
      @(negedge clk);
      tests = tests + 1;
      if (wr_accept || wr_reject || rwel_clear || rd_valid) begin
         fails = fails + 1;
         $display("FAIL R1: actual acc=%b rej=%b clr=%b rdv=%b expected all 0",
                  wr_accept, wr_reject, rwel_clear, rd_valid);
      end
      rst_n = 1'b1;
      step("R1 idle after reset", 0, 0, 0, 0, 0);

      // R2: fill the array with the gate open
      for (int a = 0; a < DEPTH; a++) step("R2", 1, 1, a, (a ^ 8'h5A) & 8'hFF, 0);
      step("R9 read", 1, 0, 9'h000, 0, 0);
      step("R9 read", 1, 0, 9'h1FF, 0, 0);

      // R3 upper quarter
      step("R3 below", 1, 1, 9'h17F, 8'hA1, 1);
      step("R3 edge", 1, 1, 9'h180, 8'hA2, 1);
      step("R3 top", 1, 1, 9'h1FF, 8'hA3, 1);
      step("R6 read 180", 1, 0, 9'h180, 0, 1);
      step("R6 read 17F", 1, 0, 9'h17F, 0, 1);

      // R4 upper half
      step("R4 below", 1, 1, 9'h0FF, 8'hB1, 2);
      step("R4 edge", 1, 1, 9'h100, 8'hB2, 2);
      step("R4 mid", 1, 1, 9'h17F, 8'hB3, 2);
      step("R6 read 100", 1, 0, 9'h100, 0, 2);

      // R5 whole array
      step("R5 zero", 1, 1, 9'h000, 8'hC1, 3);
      step("R5 low half", 1, 1, 9'h0FF, 8'hC2, 3);
      step("R7 idle", 0, 1, 9'h000, 8'hC3, 3);
      step("R9 read locked", 1, 0, 9'h000, 0, 3);
      step("R9 read locked", 1, 0, 9'h0FF, 0, 3);

      // R10 code change between back-to-back requests
      step("R10 open", 1, 1, 9'h1A0, 8'hD1, 0);
      step("R10 locked", 1, 1, 9'h1A0, 8'hD2, 1);
      step("R10 open again", 1, 1, 9'h0A0, 8'hD3, 2);
      step("R10 locked all", 1, 1, 9'h0A0, 8'hD4, 3);
      step("R6 read 1A0", 1, 0, 9'h1A0, 0, 3);
      step("R6 read 0A0", 1, 0, 9'h0A0, 0, 0);
      step("R8 idle", 0, 0, 0, 0, 0);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule